// File: doc/BRIEF.md
# Block Address Translation Matcher

This block decides whether an effective address falls inside one of a small set of programmable memory blocks and, if it does, produces the physical page address and the access rights for that block. Two banks of entries are kept, one consulted for instruction fetches and one for loads and stores. Each entry is a pair of 32-bit words (upper and lower) loaded through a simple write port. A lookup is presented for one cycle. Its result is registered and appears on the following cycle as a hit with real page address, rights and a permission-fault flag, or as a miss so that a page-table walk can take over.

Block size is variable. A length field widens the block by clearing low bits of the compare mask. Entry validity depends on whether the access runs in supervisor or user state. A global format input switches every entry to an alternate layout. In that layout the valid bit and length field live in the lower word and the rights come from a key/protection-code scheme.

Top module: `blkxlat_match`

## Requirements
- R1: While reset is asserted `rspValid` is 0, and after reset every entry word is zero, so any lookup misses.
- R2: A lookup sampled with `reqValid` high at a rising edge produces `rspValid` high for exactly the next cycle, reflecting that request. With `reqValid` low, `rspValid` is low one cycle later.
- R3: A write with `wrEn` high stores `wrData` in the entry `wrIdx` of the instruction bank (`wrInstr`=1) or the data bank (`wrInstr`=0), upper word if `wrUpper`=1 and lower word otherwise. A lookup in the same cycle as a write sees the old contents, and a lookup in the next cycle sees the new ones.
- R4: Standard format (`altFormat`=0): the upper word holds the block page index in bits 31:17, a length field in bits 12:2, a supervisor-valid bit in bit 1 and a user-valid bit in bit 0. The mask is 0xFFFE0000 with ((upper & 0x1FFC) << 15) cleared from it. The entry is valid only if bit 1 is set (`reqUser`=0) or bit 0 is set (`reqUser`=1). An invalid entry never hits. A hit needs a nonzero mask and (ea & mask) == (upper & mask).
- R5: On a hit `rspAddr` = ((lower & mask) | (ea & ~mask)) with bits 11:0 forced to zero.
- R6: Standard format rights come from lower word bits 1:0. Code 0 grants nothing, 2 grants read, write and execute, 1 and 3 grant read and execute. `rspProt` bit 0 is read, bit 1 write and bit 2 execute.
- R7: `reqKind` 2 (fetch) searches the instruction bank. `reqKind` 0 (load), 1 (store) and 3 (treated as load) search the data bank.
- R8: When several entries of the searched bank hit, the lowest index supplies the result.
- R9: Alternate format (`altFormat`=1): validity is lower bit 6 regardless of privilege. The mask is 0xFFFE0000 with ((lower & 0x3F) << 17) cleared. The key is upper bit 3 for supervisor and upper bit 2 for user, and the code is upper bits 1:0. With key 0, codes 0 to 2 grant read/write and 3 grants read. With key 1, code 0 grants nothing, 2 grants read/write, and 1 and 3 grant read. Execute is always granted.
- R10: If the right the access needs (read for load, write for store, execute for fetch) is missing on a hit, `rspFault` is 1 and `rspCode` is 0x0A000000 for a store and 0x08000000 for a load or fetch. Otherwise `rspFault` is 0 and `rspCode` is 0.
- R11: On a miss `rspHit`, `rspFault`, `rspProt`, `rspCode` and `rspAddr` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Entry word write strobe |
| wrInstr | input | 1 | Write target bank: 1 instruction, 0 data |
| wrUpper | input | 1 | Write target word: 1 upper, 0 lower |
| wrIdx | input | IDX_W (2) | Entry index to write |
| wrData | input | 32 | Word written |
| reqValid | input | 1 | Lookup request |
| reqEa | input | 32 | Effective address |
| reqKind | input | 2 | 0 load, 1 store, 2 fetch, 3 load |
| reqUser | input | 1 | 1 user state, 0 supervisor state |
| altFormat | input | 1 | 1 selects the alternate entry layout |
| rspValid | output | 1 | Result valid, one cycle after a request |
| rspHit | output | 1 | An entry matched |
| rspAddr | output | 32 | Real page address (bits 11:0 zero) |
| rspProt | output | 3 | Granted rights: bit 0 read, 1 write, 2 execute |
| rspFault | output | 1 | Needed right missing on a hit |
| rspCode | output | 32 | Fault status word, zero when no fault |

## Verification
A corrupted entry word or a wrong bank choice shows on the ports one cycle after the request that touches it, as a wrong page address, rights set or a hit that should have been a miss. A broken priority encoder only shows when overlapping entries are present, so the directed scenarios place a supervisor-only entry and a user-visible entry on the same block. Write-versus-lookup ordering is probed by issuing both in the same cycle. Format and privilege decode errors are exposed by lookups that change only `reqUser` or `altFormat` against the same stored words.

// File: rtl/blkxlat_pkg.sv
package blkxlat_pkg;

  localparam int WORD_W = 32;
  localparam int PAGE_BITS = 12;

  // standard layout
  localparam int IDX_FIELD_LSB = 17;
  localparam int STD_LEN_HI = 12;
  localparam int STD_LEN_LO = 2;
  localparam int STD_LEN_SHIFT = 15;
  localparam int SUP_VALID_BIT = 1;
  localparam int USR_VALID_BIT = 0;

  // alternate layout
  localparam int ALT_VALID_BIT = 6;
  localparam int ALT_LEN_HI = 5;
  localparam int ALT_LEN_LO = 0;
  localparam int ALT_LEN_SHIFT = 17;
  localparam int KEY_SUP_BIT = 3;
  localparam int KEY_USR_BIT = 2;

  localparam logic [WORD_W-1:0] IDX_FIELD = {{(WORD_W-IDX_FIELD_LSB){1'b1}}, {IDX_FIELD_LSB{1'b0}}};
  localparam logic [WORD_W-1:0] PAGE_MASK = {{(WORD_W-PAGE_BITS){1'b1}}, {PAGE_BITS{1'b0}}};

  localparam logic [WORD_W-1:0] CODE_DENY_WR = 32'h0A00_0000;
  localparam logic [WORD_W-1:0] CODE_DENY_RD = 32'h0800_0000;

  // rights vector bit positions
  localparam int RT_RD = 0;
  localparam int RT_WR = 1;
  localparam int RT_EX = 2;

  typedef enum logic [1:0] {
    KIND_LOAD  = 2'd0,
    KIND_STORE = 2'd1,
    KIND_FETCH = 2'd2,
    KIND_SPARE = 2'd3
  } accKind_e;

  typedef struct packed {
    logic wrUpper;
    logic wrLower;
    logic wrInstr;
    logic capture;
    logic useInstr;
    logic needRd;
    logic needWr;
    logic needEx;
    logic isStore;
  } ctlStrobe_t;

  function automatic logic [2:0] stdRights(input logic [1:0] code);
    case (code)
      2'd0:    stdRights = 3'b000;
      2'd2:    stdRights = 3'b111;
      default: stdRights = 3'b101;
    endcase
  endfunction

  function automatic logic [2:0] keyRights(input logic key, input logic [1:0] code);
    logic [1:0] rw;
    if (!key) rw = (code == 2'd3) ? 2'b01 : 2'b11;
    else begin
      case (code)
        2'd0:    rw = 2'b00;
        2'd2:    rw = 2'b11;
        default: rw = 2'b01;
      endcase
    end
    keyRights = {1'b1, rw};
  endfunction

endpackage

// File: rtl/blkxlat_ctl.sv
module blkxlat_ctl
  import blkxlat_pkg::*;
(
  input  logic       wrEn,
  input  logic       wrInstr,
  input  logic       wrUpper,
  input  logic       reqValid,
  input  logic [1:0] reqKind,
  output ctlStrobe_t strobe
);

  accKind_e kind;

  always_comb begin
    kind = accKind_e'(reqKind);
    strobe = '0;
    strobe.wrUpper  = wrEn & wrUpper;
    strobe.wrLower  = wrEn & ~wrUpper;
    strobe.wrInstr  = wrInstr;
    strobe.capture  = reqValid;
    strobe.useInstr = (kind == KIND_FETCH);
    strobe.needRd   = (kind == KIND_LOAD) || (kind == KIND_SPARE);
    strobe.needWr   = (kind == KIND_STORE);
    strobe.needEx   = (kind == KIND_FETCH);
    strobe.isStore  = (kind == KIND_STORE);
  end

endmodule

// File: rtl/blkxlat_entry.sv
module blkxlat_entry
  import blkxlat_pkg::*;
(
  input  logic [WORD_W-1:0] upWord,
  input  logic [WORD_W-1:0] loWord,
  input  logic [WORD_W-1:0] ea,
  input  logic              user,
  input  logic              alt,
  output logic              hit,
  output logic [2:0]        rights,
  output logic [WORD_W-1:0] realPage
);

  logic [WORD_W-1:0] stdLen, altLen, stdMask, altMask, mask;
  logic valid, key;

  always_comb begin
    stdLen = '0;
    stdLen[STD_LEN_HI:STD_LEN_LO] = upWord[STD_LEN_HI:STD_LEN_LO];
    altLen = '0;
    altLen[ALT_LEN_HI:ALT_LEN_LO] = loWord[ALT_LEN_HI:ALT_LEN_LO];
    stdMask = IDX_FIELD & ~(stdLen << STD_LEN_SHIFT);
    altMask = IDX_FIELD & ~(altLen << ALT_LEN_SHIFT);

    if (alt) valid = loWord[ALT_VALID_BIT];
    else     valid = user ? upWord[USR_VALID_BIT] : upWord[SUP_VALID_BIT];

    mask = valid ? (alt ? altMask : stdMask) : '0;
    hit  = (mask != '0) && ((ea & mask) == (upWord & mask));
    realPage = ((loWord & mask) | (ea & ~mask)) & PAGE_MASK;

    key = user ? upWord[KEY_USR_BIT] : upWord[KEY_SUP_BIT];
    rights = alt ? keyRights(key, upWord[1:0]) : stdRights(loWord[1:0]);
  end

endmodule

// File: rtl/blkxlat_dp.sv
module blkxlat_dp
  import blkxlat_pkg::*;
#(
  parameter int NUM_ENTRIES = 4,
  localparam int IDX_W = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        strobe,
  input  logic [IDX_W-1:0]  wrIdx,
  input  logic [WORD_W-1:0] wrData,
  input  logic [WORD_W-1:0] reqEa,
  input  logic              reqUser,
  input  logic              altFormat,
  output logic              rspValid,
  output logic              rspHit,
  output logic [WORD_W-1:0] rspAddr,
  output logic [2:0]        rspProt,
  output logic              rspFault,
  output logic [WORD_W-1:0] rspCode
);

  localparam int SIDES = 2;

  logic [WORD_W-1:0] upArr [SIDES][NUM_ENTRIES];
  logic [WORD_W-1:0] loArr [SIDES][NUM_ENTRIES];

  logic [NUM_ENTRIES-1:0] entHit;
  logic [2:0]             entRights [NUM_ENTRIES];
  logic [WORD_W-1:0]      entPage   [NUM_ENTRIES];

  logic              selHit, selFault;
  logic [2:0]        selRights;
  logic [WORD_W-1:0] selPage;
  logic [2:0]        needMask;

  // entry storage
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int s = 0; s < SIDES; s++) begin
        for (int e = 0; e < NUM_ENTRIES; e++) begin
          upArr[s][e] <= '0;
          loArr[s][e] <= '0;
        end
      end
    end else if (int'(wrIdx) < NUM_ENTRIES) begin
      if (strobe.wrUpper) upArr[strobe.wrInstr][wrIdx] <= wrData;
      if (strobe.wrLower) loArr[strobe.wrInstr][wrIdx] <= wrData;
    end
  end

  // per-entry match logic on the selected bank
  for (genvar g = 0; g < NUM_ENTRIES; g++) begin : gEnt
    blkxlat_entry uEnt (
      .upWord  (upArr[strobe.useInstr][g]),
      .loWord  (loArr[strobe.useInstr][g]),
      .ea      (reqEa),
      .user    (reqUser),
      .alt     (altFormat),
      .hit     (entHit[g]),
      .rights  (entRights[g]),
      .realPage(entPage[g])
    );
  end

  // lowest index wins
  always_comb begin
    selHit = 1'b0;
    selRights = '0;
    selPage = '0;
    for (int i = 0; i < NUM_ENTRIES; i++) begin
      if (entHit[i] && !selHit) begin
        selHit = 1'b1;
        selRights = entRights[i];
        selPage = entPage[i];
      end
    end
    needMask = '0;
    needMask[RT_RD] = strobe.needRd;
    needMask[RT_WR] = strobe.needWr;
    needMask[RT_EX] = strobe.needEx;
    selFault = selHit && ((needMask & ~selRights) != '0);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      rspHit   <= 1'b0;
      rspAddr  <= '0;
      rspProt  <= '0;
      rspFault <= 1'b0;
      rspCode  <= '0;
    end else begin
      rspValid <= strobe.capture;
      if (strobe.capture) begin
        rspHit   <= selHit;
        rspAddr  <= selHit ? selPage : '0;
        rspProt  <= selHit ? selRights : '0;
        rspFault <= selFault;
        rspCode  <= selFault ? (strobe.isStore ? CODE_DENY_WR : CODE_DENY_RD) : '0;
      end
    end
  end

endmodule

// File: rtl/blkxlat_match.sv
module blkxlat_match
  import blkxlat_pkg::*;
#(
  parameter int NUM_ENTRIES = 4,
  localparam int IDX_W = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              wrInstr,
  input  logic              wrUpper,
  input  logic [IDX_W-1:0]  wrIdx,
  input  logic [31:0]       wrData,
  input  logic              reqValid,
  input  logic [31:0]       reqEa,
  input  logic [1:0]        reqKind,
  input  logic              reqUser,
  input  logic              altFormat,
  output logic              rspValid,
  output logic              rspHit,
  output logic [31:0]       rspAddr,
  output logic [2:0]        rspProt,
  output logic              rspFault,
  output logic [31:0]       rspCode
);

  ctlStrobe_t strobe;

  blkxlat_ctl uCtl (
    .wrEn    (wrEn),
    .wrInstr (wrInstr),
    .wrUpper (wrUpper),
    .reqValid(reqValid),
    .reqKind (reqKind),
    .strobe  (strobe)
  );

  blkxlat_dp #(.NUM_ENTRIES(NUM_ENTRIES)) uDp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .wrIdx    (wrIdx),
    .wrData   (wrData),
    .reqEa    (reqEa),
    .reqUser  (reqUser),
    .altFormat(altFormat),
    .rspValid (rspValid),
    .rspHit   (rspHit),
    .rspAddr  (rspAddr),
    .rspProt  (rspProt),
    .rspFault (rspFault),
    .rspCode  (rspCode)
  );

endmodule

// File: rtl/blkxlat_chk.sv
module blkxlat_chk (
  input logic        clk,
  input logic        rstN,
  input logic        reqValid,
  input logic [1:0]  reqKind,
  input logic        altFormat,
  input logic        rspValid,
  input logic        rspHit,
  input logic [31:0] rspAddr,
  input logic [2:0]  rspProt,
  input logic        rspFault,
  input logic [31:0] rspCode
);

  AST_RSP_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> rspValid); // R2

  AST_RSP_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !rspValid); // R2

  AST_MISS_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && !rspHit) |-> (rspProt == 3'b000 && !rspFault && rspCode == 32'h0 && rspAddr == 32'h0)); // R11

  AST_PAGE_ALIGN: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> (rspAddr[11:0] == 12'h000)); // R5

  AST_WRITE_HAS_READ: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspHit && rspProt[1]) |-> (rspProt[0] && rspProt[2])); // R6

  AST_ALT_EXEC: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspHit && $past(altFormat)) |-> rspProt[2]); // R9

  AST_STORE_CODE: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspFault && $past(reqKind) == 2'd1) |-> (rspCode == 32'h0A00_0000)); // R10

  AST_OTHER_CODE: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspFault && $past(reqKind) != 2'd1) |-> (rspCode == 32'h0800_0000)); // R10

  AST_FAULT_ON_HIT: assert property (@(posedge clk) disable iff (!rstN)
    rspFault |-> rspHit); // R10

endmodule

bind blkxlat_match blkxlat_chk uChk (.*);

// File: tb/sim_blkxlat_match.sv
`timescale 1ns/1ps
module sim_blkxlat_match;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0, wrInstr = 1'b0, wrUpper = 1'b0;
  logic [1:0]  wrIdx = '0;
  logic [31:0] wrData = '0;
  logic        reqValid = 1'b0;
  logic [31:0] reqEa = '0;
  logic [1:0]  reqKind = '0;
  logic        reqUser = 1'b0, altFormat = 1'b0;
  logic        rspValid, rspHit, rspFault;
  logic [31:0] rspAddr, rspCode;
  logic [2:0]  rspProt;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  localparam logic [31:0] DWR = 32'h0A00_0000;
  localparam logic [31:0] DRD = 32'h0800_0000;

  always #2.5 clk = ~clk;

  blkxlat_match u0 (.*);

  task automatic expect1(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wrWord(input logic inst, input logic up, input logic [1:0] idx, input logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrInstr = inst; wrUpper = up; wrIdx = idx; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic wrEntry(input logic inst, input logic [1:0] idx, input logic [31:0] up, input logic [31:0] lo);
    wrWord(inst, 1'b1, idx, up);
    wrWord(inst, 1'b0, idx, lo);
  endtask

  // one lookup; result compared as {valid,hit,fault,prot,addr,code}
  task automatic look(input string req, input logic [31:0] ea, input logic [1:0] kind,
                      input logic user, input logic alt, input logic hit,
                      input logic [31:0] addr, input logic [2:0] prot, input logic [31:0] code);
    @(negedge clk);
    reqValid = 1'b1; reqEa = ea; reqKind = kind; reqUser = user; altFormat = alt;
    @(negedge clk);
    reqValid = 1'b0;
    checks++;
    if ({rspValid, rspHit, rspFault, rspProt, rspAddr, rspCode} !==
        {1'b1, hit, (code != 0), prot, addr, code}) begin
      fails++;
      $display("FAIL %s actual v=%b h=%b f=%b p=%b a=%h c=%h expected v=1 h=%b f=%b p=%b a=%h c=%h",
               req, rspValid, rspHit, rspFault, rspProt, rspAddr, rspCode,
               hit, (code != 0), prot, addr, code);
    end
  endtask

  task automatic testReset();
    expect1("R1 rspValid in reset", {31'b0, rspValid}, 32'h0);
    @(negedge clk); rstN = 1'b1;
    look("R1 empty data bank", 32'h1000_0000, 2'd0, 1'b0, 1'b0, 1'b0, 32'h0, 3'b000, 32'h0);
    look("R1 empty instr bank", 32'h1000_0000, 2'd2, 1'b0, 1'b0, 1'b0, 32'h0, 3'b000, 32'h0);
  endtask

  task automatic testPulse();
    @(negedge clk);
    expect1("R2 rspValid drops", {31'b0, rspValid}, 32'h0);
  endtask

  task automatic testStandard();
    wrEntry(1'b0, 2'd0, 32'h1000_0002, 32'h8000_0002);
    look("R4 R5 R6 supervisor hit", 32'h1001_2345, 2'd0, 1'b0, 1'b0, 1'b1, 32'h8001_2000, 3'b111, 32'h0);
    look("R4 user invalid", 32'h1001_2345, 2'd0, 1'b1, 1'b0, 1'b0, 32'h0, 3'b000, 32'h0);
    look("R4 R11 outside block", 32'h1002_0000, 2'd0, 1'b0, 1'b0, 1'b0, 32'h0, 3'b000, 32'h0);
  endtask

  task automatic testLength();
    wrEntry(1'b0, 2'd1, 32'h2000_000F, 32'h4000_0001);
    look("R4 R5 R10 store on read-only", 32'h2007_6543, 2'd1, 1'b1, 1'b0, 1'b1, 32'h4007_6000, 3'b101, DWR);
    look("R6 R10 load on read-only", 32'h2007_6543, 2'd0, 1'b1, 1'b0, 1'b1, 32'h4007_6000, 3'b101, 32'h0);
  endtask

  task automatic testPriority();
    wrEntry(1'b0, 2'd2, 32'h1000_0003, 32'h9000_0003);
    look("R8 lowest index wins", 32'h1000_0000, 2'd0, 1'b0, 1'b0, 1'b1, 32'h8000_0000, 3'b111, 32'h0);
    look("R8 R4 higher entry for user", 32'h1000_0000, 2'd0, 1'b1, 1'b0, 1'b1, 32'h9000_0000, 3'b101, 32'h0);
  endtask

  task automatic testSides();
    wrEntry(1'b1, 2'd0, 32'h1000_0003, 32'hA000_0000);
    look("R7 R10 fetch uses instr bank", 32'h1000_0000, 2'd2, 1'b0, 1'b0, 1'b1, 32'hA000_0000, 3'b000, DRD);
    look("R7 fetch misses data-only block", 32'h2000_0000, 2'd2, 1'b0, 1'b0, 1'b0, 32'h0, 3'b000, 32'h0);
    look("R7 kind 3 as load", 32'h2000_0000, 2'd3, 1'b1, 1'b0, 1'b1, 32'h4000_0000, 3'b101, 32'h0);
    wrEntry(1'b0, 2'd3, 32'h3000_0002, 32'hB000_0000);
    look("R10 load with no rights", 32'h3000_0000, 2'd0, 1'b0, 1'b0, 1'b1, 32'hB000_0000, 3'b000, DRD);
  endtask

  task automatic testWriteOrder();
    @(negedge clk);
    wrEn = 1'b1; wrInstr = 1'b0; wrUpper = 1'b0; wrIdx = 2'd3; wrData = 32'hB000_0002;
    reqValid = 1'b1; reqEa = 32'h3000_0000; reqKind = 2'd0; reqUser = 1'b0; altFormat = 1'b0;
    @(negedge clk);
    wrEn = 1'b0; reqValid = 1'b0;
    expect1("R3 same-cycle lookup sees old rights", {29'b0, rspProt}, 32'h0);
    look("R3 next lookup sees new word", 32'h3000_0000, 2'd0, 1'b0, 1'b0, 1'b1, 32'hB000_0000, 3'b111, 32'h0);
  endtask

  task automatic testAlternate();
    wrEntry(1'b0, 2'd0, 32'h1000_0005, 32'h8000_0041);
    look("R9 key0 code1 store", 32'h1003_1234, 2'd1, 1'b0, 1'b1, 1'b1, 32'h8003_1000, 3'b111, 32'h0);
    look("R9 R10 key1 code1 store", 32'h1003_1234, 2'd1, 1'b1, 1'b1, 1'b1, 32'h8003_1000, 3'b101, DWR);
    look("R9 length boundary", 32'h1004_1234, 2'd0, 1'b0, 1'b1, 1'b0, 32'h0, 3'b000, 32'h0);
    look("R9 lower valid bit clear", 32'h2000_0000, 2'd0, 1'b0, 1'b1, 1'b0, 32'h0, 3'b000, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    testPulse();
    testStandard();
    testLength();
    testPriority();
    testSides();
    testWriteOrder();
    testAlternate();
    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule